// File: doc/BRIEF.md
# Pseudo-Random Bit and Word Generator

This block is a shift register with linear feedback that produces a pseudo-random serial bit stream and, alongside it, an M-bit parallel word meant for driving a digital-to-analog converter. On each enabled clock the register moves one place toward its most significant stage. The new bit entering stage 1 is the parity of a fixed set of tap stages, and the output stage is always one of those taps.

A detector watches for the register holding all zeros. An XOR-only register can never leave that state. When the detector sees it, the feedback is forced to 1, so the register escapes on the next enabled clock and no constraint on the seed is needed. During the normal sequence the detector never fires, so a maximal tap set keeps its full period of 2^N-1 states.

The parallel word is the top M stages of the register. It updates on the same edge as the serial bit. With M equal to N, the word visits every nonzero value once per period. With M below N, the values are truncated but their distribution stays flat.

Top module: `lfsr_gen`

## Requirements
- R1: A synchronous active-high `rst` loads the register with parameter `SEED` (default all ones). The loaded value appears on the outputs after that clock edge, and `rst` takes priority over `en`.
- R2: On a rising edge with `en` high and `rst` low, the register shifts one stage toward the MSB. The new bit 0 is the XOR of every stage k whose `TAP_MASK` bit k-1 is set (default mask 16'hD008, stages 16, 15, 13 and 4). `ser_out` is the MSB.
- R3: While `en` is low, the register, `ser_out` and `par_out` hold their values.
- R4: If the register is all zeros, the next enabled edge loads the value 1 (only bit 0 set). A nonzero register never becomes zero.
- R5: With the default taps, the 16-bit register returns to a given state after exactly 65535 enabled steps and no earlier.
- R6: With maximal taps, `ser_out` never shows more than N equal bits in a row over enabled steps.
- R7: `par_out` equals register bits N-1 down to N-M, with `par_out[M-1]` being the MSB. It is valid after the same edge as `ser_out`.
- R8: When M equals N, each nonzero `par_out` value appears exactly once in any 2^N-1 consecutive enabled steps, and zero never appears.
- R9: When M is less than N, over any 2^N-1 consecutive enabled steps each nonzero M-bit value appears 2^(N-M) times and zero appears 2^(N-M)-1 times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, loads SEED |
| en | input | 1 | Step enable, one shift per enabled clock |
| ser_out | output | 1 | Serial pseudo-random bit (register MSB) |
| par_out | output | M | Parallel word, top M register bits |

## Verification
Every result is due on the first rising edge after the stimulus. A reset, a step or a hold shows up on both outputs at that edge, with no further pipeline stage. The bench therefore drives `en` and `rst` on the falling edge and samples both outputs on the next falling edge. At that point a behavioural model, stepped once per cycle, already holds the expected value.

Properties over a whole period (R5, R6, R8, R9) are gathered from port samples over an unbroken run of enabled cycles. The period is measured as the distance between two occurrences of sixteen ones in a row on `ser_out`.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

  // Default length and tap mask for the polynomial x^16 + x^15 + x^13 + x^4 + 1.
  // Mask bit k-1 selects stage k.
  localparam int          DEF_LEN  = 16;
  localparam int          DEF_WORD = 4;
  localparam logic [15:0] DEF_TAPS = 16'hD008;

endpackage

// File: rtl/lfsr_feedback.sv
module lfsr_feedback #(
  parameter int             N        = 16,
  parameter logic [N-1:0]   TAP_MASK = lfsr_pkg::DEF_TAPS
) (
  input  logic [N-1:0] state,
  output logic         fb
);

  logic [N-1:0] tapped;
  logic         parity;
  logic         all_zero;

  for (genvar i = 0; i < N; i++) begin : g_tap
    if (TAP_MASK[i]) begin : g_on
      assign tapped[i] = state[i];
    end else begin : g_off
      assign tapped[i] = 1'b0;
    end
  end

  assign parity   = ^tapped;
  assign all_zero = ~|state;
  assign fb       = parity | all_zero;

endmodule

// File: rtl/lfsr_shift_reg.sv
module lfsr_shift_reg #(
  parameter int           N    = 16,
  parameter logic [N-1:0] SEED = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         fb,
  output logic [N-1:0] state_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEED;
    end else if (en) begin
      state_q <= {state_q[N-2:0], fb};
    end
  end

endmodule

// File: rtl/lfsr_gen.sv
module lfsr_gen #(
  parameter int           N        = lfsr_pkg::DEF_LEN,
  parameter int           M        = lfsr_pkg::DEF_WORD,
  parameter logic [N-1:0] TAP_MASK = lfsr_pkg::DEF_TAPS,
  parameter logic [N-1:0] SEED     = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic         ser_out,
  output logic [M-1:0] par_out
);

  localparam int MSB = N - 1;
  localparam int LSB_WORD = N - M;

  logic [N-1:0] state_q;
  logic         fb;

  lfsr_feedback #(.N(N), .TAP_MASK(TAP_MASK)) u_fb (
    .state (state_q),
    .fb    (fb)
  );

  lfsr_shift_reg #(.N(N), .SEED(SEED)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .fb      (fb),
    .state_q (state_q)
  );

  assign ser_out = state_q[MSB];
  assign par_out = state_q[MSB:LSB_WORD];

endmodule

module lfsr_gen_chk #(
  parameter int           N    = 16,
  parameter logic [N-1:0] SEED = '1
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic [N-1:0] state
);

  assert_seed_R1: assert property (@(posedge clk) rst |=> state == SEED);

  assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
    en |=> state[N-1:1] == $past(state[N-2:0]));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(state));

  assert_escape_R4: assert property (@(posedge clk) disable iff (rst)
    (en && state == '0) |=> state == {{(N-1){1'b0}}, 1'b1});

  assert_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    (state != '0) |=> state != '0);

endmodule

bind lfsr_gen lfsr_gen_chk #(.N(N), .SEED(SEED)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .en    (en),
  .state (state_q)
);

// File: tb/test_lfsr_gen.sv
module test_lfsr_gen;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic rst, en;
  logic       ser_a, ser_b, ser_c;
  logic [3:0] par_a, par_b;
  logic [7:0] par_c;

  lfsr_gen i_lfsr_gen (.clk(clk), .rst(rst), .en(en), .ser_out(ser_a), .par_out(par_a));
  lfsr_gen #(.N(4), .M(4), .TAP_MASK(4'b1100), .SEED(4'b1000)) i_lfsr_small (
    .clk(clk), .rst(rst), .en(en), .ser_out(ser_b), .par_out(par_b));
  lfsr_gen #(.N(8), .M(8), .TAP_MASK(8'hB8), .SEED(8'h00)) i_lfsr_zero (
    .clk(clk), .rst(rst), .en(en), .ser_out(ser_c), .par_out(par_c));

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  int ta[$] = '{16, 15, 13, 4};
  int tb[$] = '{4, 3};
  int tc[$] = '{8, 6, 5, 4};

  int unsigned ma, mb, mc;

  function automatic int unsigned model_next(int unsigned s, int n, int taps[$]);
    int unsigned f = 0;
    foreach (taps[k]) f ^= (s >> (taps[k] - 1)) & 1;
    if (s == 0) f = 1;
    return ((s << 1) | f) & ((32'd1 << n) - 1);
  endfunction

  task automatic chk(string req, int unsigned act, int unsigned exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 serial main", ser_a, (ma >> 15) & 1);
    chk("R7 word main", par_a, ma >> 12);
    chk("R2 serial small", ser_b, (mb >> 3) & 1);
    chk("R2 word small", par_b, mb);
    chk("R2 word zero-seed", par_c, mc);
  endtask

  task automatic tick(bit e);
    en = e;
    @(posedge clk);
    @(negedge clk);
    if (rst) begin
      ma = 16'hFFFF; mb = 4'b1000; mc = 0;
    end else if (e) begin
      ma = model_next(ma, 16, ta);
      mb = model_next(mb, 4, tb);
      mc = model_next(mc, 8, tc);
    end
    compare_all();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  int run = 0, maxrun = 0, last = -1;
  int ev[$];
  int ha[16];
  int hb[16];

  initial begin
    logic [3:0] sa;
    logic [7:0] sc;
    rst = 1'b1; en = 1'b0;
    @(negedge clk);
    tick(0);
    tick(1);
    chk("R1 reset serial", ser_a, 1);
    chk("R1 reset word", par_a, 4'hF);
    chk("R1 reset small", par_b, 4'b1000);
    chk("R1 reset zero seed", par_c, 0);

    rst = 1'b0;
    tick(1);
    chk("R4 escape from zero", par_c, 8'h01);
    tick(1);
    tick(1);

    sa = par_a; sc = par_c;
    for (int i = 0; i < 3; i++) begin
      tick(0);
      chk("R3 hold main", par_a, sa);
      chk("R3 hold zero-seed", par_c, sc);
    end

    rst = 1'b1;
    tick(1);
    chk("R1 reset mid-run", par_a, 4'hF);
    rst = 1'b0;

    foreach (ha[k]) ha[k] = 0;
    foreach (hb[k]) hb[k] = 0;
    for (int i = 0; i <= 65600; i++) begin
      if (i > 0) tick(1);
      if (ser_a == last) run++; else run = 1;
      last = ser_a;
      if (run > maxrun) maxrun = run;
      if (ser_a && run == 16) ev.push_back(i);
      if (i >= 1 && i <= 65535) ha[par_a]++;
      if (i >= 1 && i <= 15) hb[par_b]++;
    end

    chk("R6 longest run", (maxrun <= 16), 1);
    chk("R5 period events", ev.size(), 2);
    if (ev.size() == 2) chk("R5 period length", ev[1] - ev[0], 65535);
    for (int v = 0; v < 16; v++) begin
      chk("R9 truncated word count", ha[v], (v == 0) ? 4095 : 4096);
      chk("R8 full word count", hb[v], (v == 0) ? 0 : 1);
    end

    finished = 1;
    summary();
  end

endmodule